// File: doc/BRIEF.md
# Gated Neighbour-Sum Saturating Node Update

This block computes one node update for a graph-style network. Each of 22 neighbours supplies a signed 9-bit weight and a one-bit state. A weight enters the sum only when its neighbour's state is 1. A signed 9-bit bias is always added. Every operand is sign-extended to a 14-bit accumulator, so the full sum is exact. The result is then clamped back into the signed 9-bit range.

The 9-bit values are read as signed fixed point with two fractional bits, which gives a range of -64.0 to +63.75. The clamp limits are those two extremes. The selects act as a mask, not a multiplier. The adds form a balanced binary tree five levels deep.

A parameter picks one of two output forms. One is purely combinational. The other is registered on the rising clock edge, with a synchronous reset to zero.

Top module: `nsc_node_update`

## Requirements
- R1: A weight whose select bit is 0 contributes nothing to the sum, whatever its value. With all selects at 0, the result equals the bias.
- R2: The signed bias is always added to the gated sum, independent of the selects.
- R3: The sum is formed exactly in 14-bit two's complement. Large intermediate totals that cancel back into range give the exact in-range value, with no 9-bit wrap-around. For example, eleven weights of +255 and eleven of -256 with a zero bias give -11 (0x1F5).
- R4: When the exact signed sum is greater than +255 (+63.75), the result is 0x0FF. A sum of exactly 256 already clamps.
- R5: When the exact signed sum is less than -256 (-64.0), the result is 0x100. A sum of exactly -257 already clamps.
- R6: When the sum lies in [-256, +255], the result is the low 9 bits of the sum. The endpoints 255 (0x0FF) and -256 (0x100) pass through unchanged.
- R7: With REG_OUT=1, the output is zero in the cycle after any rising edge that samples rst high. Otherwise the output at each edge takes the result computed from the inputs present before that edge, one cycle of latency.
- R8: With REG_OUT=0, the output follows the inputs combinationally in the same cycle, and clk and rst have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| weight_i | input | N_TERMS x W_IN (22 x 9) | Signed neighbour weights; element k belongs to select k |
| sel_i | input | N_TERMS (22) | Neighbour states; bit k gates weight k |
| bias_i | input | W_IN (9) | Signed bias, always added |
| node_o | output | W_IN (9) | Saturated signed node value |

## Verification
On every cycle, the assertions tie the clamp output to the tree sum. The output must be the upper limit above range, the lower limit below range, and the low bits inside it. They also check that an all-zero select vector leaves exactly the sign-extended bias, and that the registered output trails the clamp by one edge.

The assertions cannot show that the tree sum itself is the right arithmetic total of the gated operands. Only the bench's scenarios show that, together with the exact boundary values 255/256 and -256/-257, the cancelling wide sums, and the reset behaviour. The bench compares both output variants against an integer reference model.

// File: rtl/nsc_pkg.sv
package nsc_pkg;

   // Smallest power of two that is >= n (n >= 1).
   function automatic int unsigned pow2_ceil(input int unsigned n);
      int unsigned p;
      p = 1;
      while (p < n) p = p << 1;
      return p;
   endfunction

   // Number of bits needed to hold the sum of n operands of width w.
   function automatic int unsigned sum_width(input int unsigned w, input int unsigned n);
      return w + $clog2(n);
   endfunction

endpackage

// File: rtl/nsc_gate.sv
module nsc_gate #(
   parameter int unsigned N_TERMS = 22,
   parameter int unsigned W_IN    = 9,
   parameter int unsigned W_ACC   = 14,
   parameter int unsigned LEAVES  = 32
) (
   input  logic [N_TERMS-1:0][W_IN-1:0] weight_i,
   input  logic [N_TERMS-1:0]           sel_i,
   input  logic [W_IN-1:0]              bias_i,
   output logic [LEAVES-1:0][W_ACC-1:0] leaf_o
);
   localparam int unsigned EXT = W_ACC - W_IN;

   initial begin
      assert (LEAVES >= N_TERMS + 1)
         else $error("nsc_gate: LEAVES too small for terms plus bias");
      assert (W_ACC > W_IN)
         else $error("nsc_gate: accumulator must be wider than operands");
   end

   // One leaf per slot: gated weights, then the bias, then zero padding.
   for (genvar g = 0; g < LEAVES; g++) begin : g_leaf
      if (g < N_TERMS) begin : g_term
         assign leaf_o[g] = {{EXT{weight_i[g][W_IN-1]}}, weight_i[g]} & {W_ACC{sel_i[g]}};
      end else if (g == N_TERMS) begin : g_bias
         assign leaf_o[g] = {{EXT{bias_i[W_IN-1]}}, bias_i};
      end else begin : g_pad
         assign leaf_o[g] = '0;
      end
   end

endmodule

// File: rtl/nsc_tree.sv
module nsc_tree #(
   parameter int unsigned LEAVES = 32,
   parameter int unsigned W_ACC  = 14
) (
   input  logic [LEAVES-1:0][W_ACC-1:0] leaf_i,
   output logic [W_ACC-1:0]             sum_o
);
   localparam int unsigned NODES = 2 * LEAVES - 1;

   initial begin
      assert ((LEAVES & (LEAVES - 1)) == 0 && LEAVES >= 2)
         else $error("nsc_tree: LEAVES must be a power of two >= 2");
   end

   // Heap layout: node k has children 2k+1 and 2k+2, leaves at the tail.
   logic [W_ACC-1:0] heap [NODES];

   always_comb begin
      for (int i = 0; i < int'(LEAVES); i++) begin
         heap[int'(LEAVES) - 1 + i] = leaf_i[i];
      end
      for (int k = int'(LEAVES) - 2; k >= 0; k--) begin
         heap[k] = heap[2*k + 1] + heap[2*k + 2];
      end
   end

   assign sum_o = heap[0];

endmodule

// File: rtl/nsc_clamp.sv
module nsc_clamp #(
   parameter int unsigned W_IN  = 9,
   parameter int unsigned W_ACC = 14
) (
   input  logic [W_ACC-1:0] sum_i,
   output logic [W_IN-1:0]  val_o
);
   localparam logic signed [W_ACC-1:0] HI_LIM = W_ACC'((1 << (W_IN - 1)) - 1);
   localparam logic signed [W_ACC-1:0] LO_LIM = -HI_LIM - W_ACC'(1);
   localparam logic [W_IN-1:0] HI_CODE = {1'b0, {(W_IN-1){1'b1}}};
   localparam logic [W_IN-1:0] LO_CODE = {1'b1, {(W_IN-1){1'b0}}};

   logic signed [W_ACC-1:0] s;
   assign s = $signed(sum_i);

   always_comb begin
      if (s > HI_LIM)      val_o = HI_CODE;
      else if (s < LO_LIM) val_o = LO_CODE;
      else                 val_o = sum_i[W_IN-1:0];
   end

endmodule

// File: rtl/nsc_node_update.sv
module nsc_node_update #(
   parameter int unsigned N_TERMS = 22,
   parameter int unsigned W_IN    = 9,
   parameter int unsigned W_ACC   = 14,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [N_TERMS-1:0][W_IN-1:0] weight_i,
   input  logic [N_TERMS-1:0]           sel_i,
   input  logic [W_IN-1:0]              bias_i,
   output logic [W_IN-1:0]              node_o
);
   import nsc_pkg::*;

   localparam int unsigned LEAVES = pow2_ceil(N_TERMS + 1);
   localparam int unsigned EXT    = W_ACC - W_IN;
   localparam logic signed [W_ACC-1:0] HI_LIM = W_ACC'((1 << (W_IN - 1)) - 1);
   localparam logic signed [W_ACC-1:0] LO_LIM = -HI_LIM - W_ACC'(1);

   initial begin
      assert (N_TERMS >= 1) else $error("nsc_node_update: need at least one term");
      assert (W_ACC >= sum_width(W_IN, N_TERMS + 1))
         else $error("nsc_node_update: W_ACC cannot hold the exact sum");
   end

   logic [LEAVES-1:0][W_ACC-1:0] leaf_w;
   logic [W_ACC-1:0]             sum_w;
   logic [W_IN-1:0]              val_w;

   nsc_gate #(.N_TERMS(N_TERMS), .W_IN(W_IN), .W_ACC(W_ACC), .LEAVES(LEAVES)) u_gate (
      .weight_i (weight_i),
      .sel_i    (sel_i),
      .bias_i   (bias_i),
      .leaf_o   (leaf_w)
   );

   nsc_tree #(.LEAVES(LEAVES), .W_ACC(W_ACC)) u_tree (
      .leaf_i (leaf_w),
      .sum_o  (sum_w)
   );

   nsc_clamp #(.W_IN(W_IN), .W_ACC(W_ACC)) u_clamp (
      .sum_i (sum_w),
      .val_o (val_w)
   );

   // Clamp against tree sum.
   p_pos_clamp_r4: assert property (@(posedge clk) disable iff (rst)
      ($signed(sum_w) > HI_LIM) |-> (val_w == {1'b0, {(W_IN-1){1'b1}}}));
   p_neg_clamp_r5: assert property (@(posedge clk) disable iff (rst)
      ($signed(sum_w) < LO_LIM) |-> (val_w == {1'b1, {(W_IN-1){1'b0}}}));
   p_in_range_r6: assert property (@(posedge clk) disable iff (rst)
      (($signed(sum_w) <= HI_LIM) && ($signed(sum_w) >= LO_LIM)) |-> (val_w == sum_w[W_IN-1:0]));
   // Masked weights vanish: only the bias remains.
   p_gate_bias_r1: assert property (@(posedge clk) disable iff (rst)
      (sel_i == '0) |-> (sum_w == {{EXT{bias_i[W_IN-1]}}, bias_i}));

   if (REG_OUT) begin : g_reg
      logic [W_IN-1:0] q;
      always_ff @(posedge clk) begin
         if (rst) q <= '0;
         else     q <= val_w;
      end
      assign node_o = q;

      p_reg_track_r7: assert property (@(posedge clk) disable iff (rst)
         $past(!rst) |-> (node_o == $past(val_w)));
   end else begin : g_comb
      assign node_o = val_w;

      p_comb_follow_r8: assert property (@(posedge clk) disable iff (rst)
         node_o == val_w);
   end

endmodule

// File: tb/tb_nsc_node_update.sv
module tb_nsc_node_update;
   localparam int NT = 22;
   localparam int W  = 9;

   logic                clk = 1'b0;
   logic                rst = 1'b1;
   logic [NT-1:0][W-1:0] weight;
   logic [NT-1:0]       sel;
   logic [W-1:0]        bias;
   logic [W-1:0]        out_reg;
   logic [W-1:0]        out_comb;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [W-1:0] exp;
      string        tag;
   } item_t;
   item_t sb[$];

   always #5 clk = ~clk;

   nsc_node_update #(.N_TERMS(NT), .W_IN(W), .W_ACC(14), .REG_OUT(1'b1)) dut (
      .clk(clk), .rst(rst), .weight_i(weight), .sel_i(sel), .bias_i(bias), .node_o(out_reg));

   nsc_node_update #(.N_TERMS(NT), .W_IN(W), .W_ACC(14), .REG_OUT(1'b0)) dut_comb (
      .clk(clk), .rst(rst), .weight_i(weight), .sel_i(sel), .bias_i(bias), .node_o(out_comb));

   function automatic int exact_sum(input logic [NT-1:0][W-1:0] w,
                                    input logic [NT-1:0] s, input logic [W-1:0] b);
      int acc;
      acc = int'($signed(b));
      for (int i = 0; i < NT; i++) if (s[i]) acc += int'($signed(w[i]));
      return acc;
   endfunction

   function automatic logic [W-1:0] model(input int acc);
      if (acc > 255)  return 9'h0FF;
      if (acc < -256) return 9'h100;
      return acc[W-1:0];
   endfunction

   task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%03h expected 0x%03h", tag, act, exp);
      end
   endtask

   // Driver: apply a vector, check the combinational variant, queue the registered one.
   task automatic drive(input logic [NT-1:0][W-1:0] w, input logic [NT-1:0] s,
                        input logic [W-1:0] b, input string tag);
      int acc;
      item_t it;
      string t;
      @(negedge clk);
      weight = w; sel = s; bias = b;
      acc = exact_sum(w, s, b);
      t = tag;
      if (t == "") t = (acc > 255) ? "R4" : (acc < -256) ? "R5" : "R6";
      #1;
      check(out_comb, model(acc), {t, "/R8 comb"});
      it.exp = model(acc);
      it.tag = {t, "/R7 reg"};
      sb.push_back(it);
   endtask

   // Monitor: compare registered output one edge after each queued vector.
   initial begin
      item_t it;
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            it = sb.pop_front();
            check(out_reg, it.exp, it.tag);
         end
      end
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [NT-1:0][W-1:0] w;
      logic [NT-1:0]        s;
      weight = '0; sel = '0; bias = '0;

      // R7: reset holds output at zero even with a saturating input present.
      repeat (2) @(negedge clk);
      weight = {NT{9'h0FF}}; sel = '1; bias = 9'h0FF;
      @(negedge clk);
      check(out_reg, 9'h000, "R7 reset value");
      rst = 1'b0;

      // R1: all selects zero, only the bias survives.
      for (int i = 0; i < NT; i++) w[i] = 9'(i * 23 + 7);
      drive(w, '0, 9'h000, "R1 zero-sel zero-bias");
      drive(w, '0, 9'h135, "R1/R2 zero-sel neg bias");
      drive(w, '0, 9'h0FF, "R1/R2 zero-sel max bias");
      drive(w, '0, 9'h100, "R1/R2 zero-sel min bias");

      // R4: all max weights -> positive saturation.
      drive({NT{9'h0FF}}, '1, 9'h000, "R4 all max");
      // R5: all min weights -> negative saturation.
      drive({NT{9'h100}}, '1, 9'h100, "R5 all min");

      // Boundaries.
      w = '0; w[0] = 9'h0FF;
      drive(w, 22'h1, 9'h000, "R6 sum=255");
      w[1] = 9'h001;
      drive(w, 22'h3, 9'h000, "R4 sum=256");
      w = '0; w[0] = 9'h100;
      drive(w, 22'h1, 9'h000, "R6 sum=-256");
      w[1] = 9'h1FF;
      drive(w, 22'h3, 9'h000, "R5 sum=-257");
      // R2: bias pushes over the top.
      w = '0; w[5] = 9'h0F0;
      drive(w, 22'h20, 9'h010, "R2 bias to 256");

      // R3: wide cancelling sum -> -11.
      for (int i = 0; i < NT; i++) w[i] = (i < 11) ? 9'h0FF : 9'h100;
      drive(w, '1, 9'h000, "R3 cancel");
      // R1: masked large weights ignored; only one selected.
      drive({NT{9'h0FF}}, 22'h000400, 9'h1F0, "R1 single select");

      // Random vectors.
      for (int n = 0; n < 300; n++) begin
         for (int i = 0; i < NT; i++) w[i] = 9'($urandom);
         s = 22'($urandom);
         if (n % 3 == 0) begin
            for (int i = 0; i < NT; i++) w[i] = 9'($signed(6'($urandom)));
         end
         drive(w, s, 9'($urandom), "");
      end

      // R7: reset mid-run clears the registered output.
      @(negedge clk);
      rst = 1'b1;
      weight = {NT{9'h0FF}}; sel = '1;
      @(negedge clk);
      check(out_reg, 9'h000, "R7 mid-run reset");
      // R8: combinational variant ignores rst.
      check(out_comb, 9'h0FF, "R8 comb during reset");
      rst = 1'b0;

      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule